// File: doc/BRIEF.md
# SPI FIFO Word Packer and Unpacker

This block sits between a byte-oriented client and the 32-bit data FIFOs of a serial-peripheral engine. On the transmit side it collects bytes from a valid/ready stream and assembles them into FIFO words. On the receive side it takes FIFO words and returns their bytes one at a time. The number of bytes carried by one FIFO word follows from the configured frame width: one byte for narrow frames, two for mid-width frames and four for wide frames.

A transfer begins with a one-cycle `start` that carries the total byte count and the frame width in bits. The block checks that the count is a non-zero whole number of words, then counts bytes in both directions until the count is used up. When the last received byte leaves the block, a single-cycle `done` pulse marks the end. Transmit words are packed from the top of the word down, and receive words are read as right-justified values whose most significant active byte comes out first.

Top module: `spi_word_packer`

## Requirements
- R1: The bytes per word are 1 when `frame_bits` is 0 to 8, 2 when it is 9 to 16, and 4 when it is 17 to 32; the value is captured at an accepted start and holds for the whole transfer.
- R2: In a transmit word, the byte accepted at position i within that word (i counted from 0) appears on `txw_data[31-8i:24-8i]`; byte lanes at or beyond the bytes-per-word count are zero.
- R3: While `txw_valid` is high and `txw_ready` is low, `txw_valid` stays high and `txw_data` does not change, and `txb_ready` stays low while a finished word waits.
- R4: A receive word delivers its bytes in order i = 0 .. w-1 (w the bytes per word), byte i being bits [8(w-1-i)+7 : 8(w-1-i)] of the word; bits above the lowest 8w are ignored.
- R5: While `rxb_valid` is high and `rxb_ready` is low, `rxb_valid` stays high and `rxb_data` does not change, and `rxw_ready` is low whenever a received word still has bytes to give.
- R6: An accepted transfer of L bytes takes exactly L bytes on the transmit byte stream and L/w words on each word port; outside a transfer `txb_ready` and `rxw_ready` are low.
- R7: A start whose length is zero or not a multiple of the bytes per word raises `len_err`, starts nothing (`busy` stays low) and keeps `len_err` high until the next accepted start clears it.
- R8: `done` is high for exactly the one cycle following the handshake of the last received byte.
- R9: A start that arrives while `busy` is high is ignored: it changes neither the running counts nor `len_err`.
- R10: After reset, `busy`, `done`, `len_err`, `txw_valid`, `rxb_valid`, `txb_ready` and `rxw_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer (one cycle) |
| xfer_len | input | LEN_W | Transfer length in bytes, sampled with start |
| frame_bits | input | 6 | Frame width in bits, sampled with start |
| busy | output | 1 | A transfer is in progress |
| len_err | output | 1 | Last start was refused for its length |
| done | output | 1 | One-cycle end-of-transfer pulse |
| txb_valid | input | 1 | Transmit byte offered |
| txb_ready | output | 1 | Transmit byte accepted |
| txb_data | input | 8 | Transmit byte |
| txw_valid | output | 1 | Packed word ready for the output FIFO |
| txw_ready | input | 1 | Output FIFO can take a word (not full) |
| txw_data | output | 32 | Packed transmit word |
| rxw_valid | input | 1 | Input FIFO has a word (not empty) |
| rxw_ready | output | 1 | Word taken from the input FIFO |
| rxw_data | input | 32 | Received word |
| rxb_valid | output | 1 | Received byte offered |
| rxb_ready | input | 1 | Received byte taken |
| rxb_data | output | 8 | Received byte |

## Verification
The assertions watch, on every cycle, the handshake rules at both word and byte edges: held data under back-pressure, no word intake while bytes remain, no traffic outside a transfer, the single-cycle shape of `done`, and the quiet state that follows a refused start. Lane placement, byte order inside receive words, the frame-width thresholds and the exact byte and word counts depend on the data carried, so only the bench's sweeps over frame widths, lengths and stall patterns show them. Start requests during a transfer are only shown to be ignored by a scenario that completes with the original counts.

// File: rtl/spi_pack_pkg.sv
// Shared types for the SPI word packer.
// Assumes a 32-bit FIFO word made of four byte lanes.
package spi_pack_pkg;

    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = 8 * WORD_BYTES;
    localparam int LANE_IDX_W = $clog2(WORD_BYTES);

    // Bytes-per-word code; the lane count is 1 << code.
    typedef enum logic [1:0] {
        BPW_ONE  = 2'd0,
        BPW_TWO  = 2'd1,
        BPW_FOUR = 2'd2
    } bpw_e;

    // Map a frame width in bits to a bytes-per-word code.
    function automatic bpw_e bpw_from_bits(input logic [5:0] fbits);
        if (fbits <= 6'd8)       return BPW_ONE;
        else if (fbits <= 6'd16) return BPW_TWO;
        else                     return BPW_FOUR;
    endfunction

    // Index of the last active lane for a code.
    function automatic logic [LANE_IDX_W-1:0] last_lane(input bpw_e code);
        case (code)
            BPW_ONE: return LANE_IDX_W'(0);
            BPW_TWO: return LANE_IDX_W'(1);
            default: return LANE_IDX_W'(WORD_BYTES - 1);
        endcase
    endfunction

endpackage

// File: rtl/spi_len_ctrl.sv
// Transfer admission: decodes the frame width, checks the length for
// whole words and issues a one-cycle load to both data paths.
// Assumes start is only honoured when the paths are idle.
module spi_len_ctrl
    import spi_pack_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic [5:0]       frame_bits,
    input  logic             busy,
    output logic             load,
    output bpw_e             bpw,
    output logic             len_err
);

    bpw_e req_bpw;
    logic len_ok;
    logic take;

    // Decode the request and judge its length.
    always_comb begin
        req_bpw = bpw_from_bits(frame_bits);
        case (req_bpw)
            BPW_ONE: len_ok = 1'b1;
            BPW_TWO: len_ok = (xfer_len[0] == 1'b0);
            default: len_ok = (xfer_len[1:0] == 2'b00);
        endcase
        if (xfer_len == '0) len_ok = 1'b0;
        take = start && !busy;
        load = take && len_ok;
    end

    // Hold the bytes-per-word code of the running transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)    bpw <= BPW_ONE;
        else if (load) bpw <= req_bpw;
    end

    // Record whether the last considered start was refused.
    always_ff @(posedge clk) begin
        if (!rst_n)    len_err <= 1'b0;
        else if (take) len_err <= !len_ok;
    end

endmodule

// File: rtl/spi_tx_packer.sv
// Transmit path: gathers bytes into one 32-bit word, first byte in the
// top lane, and offers the word to the output FIFO.
// Assumes bpw is steady from the cycle after load to the end.
module spi_tx_packer
    import spi_pack_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LEN_W-1:0]  xfer_len,
    input  bpw_e              bpw,
    input  logic              txb_valid,
    output logic              txb_ready,
    input  logic [7:0]        txb_data,
    output logic              txw_valid,
    input  logic              txw_ready,
    output logic [WORD_W-1:0] txw_data,
    output logic              tx_busy
);

    logic [LEN_W-1:0]      left_q;
    logic [LANE_IDX_W-1:0] idx_q;
    logic                  full_q;
    logic [7:0]            lane_q [WORD_BYTES];
    logic                  byte_hs;
    logic                  word_hs;

    // Handshake decode.
    always_comb begin
        txb_ready = (left_q != '0) && !full_q;
        byte_hs   = txb_valid && txb_ready;
        word_hs   = full_q && txw_ready;
        txw_valid = full_q;
        tx_busy   = (left_q != '0) || full_q;
    end

    // Byte counter and lane pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            left_q <= xfer_len;
            idx_q  <= '0;
        end else if (byte_hs) begin
            left_q <= left_q - LEN_W'(1);
            idx_q  <= (idx_q == last_lane(bpw)) ? '0 : idx_q + LANE_IDX_W'(1);
        end
    end

    // Word-complete flag.
    always_ff @(posedge clk) begin
        if (!rst_n || load)                            full_q <= 1'b0;
        else if (byte_hs && idx_q == last_lane(bpw))   full_q <= 1'b1;
        else if (word_hs)                              full_q <= 1'b0;
    end

    // One register per byte lane, cleared between words.
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n || load || word_hs)
                lane_q[g] <= 8'h00;
            else if (byte_hs && idx_q == LANE_IDX_W'(g))
                lane_q[g] <= txb_data;
        end
        assign txw_data[WORD_W-1-8*g -: 8] = lane_q[g];
    end

endmodule

// File: rtl/spi_rx_unpacker.sv
// Receive path: takes a right-justified 32-bit word and hands out its
// active bytes, most significant first, then signals the end.
// Assumes bpw is steady from the cycle after load to the end.
module spi_rx_unpacker
    import spi_pack_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LEN_W-1:0]  xfer_len,
    input  bpw_e              bpw,
    input  logic              rxw_valid,
    output logic              rxw_ready,
    input  logic [WORD_W-1:0] rxw_data,
    output logic              rxb_valid,
    input  logic              rxb_ready,
    output logic [7:0]        rxb_data,
    output logic              rx_busy,
    output logic              done
);

    logic [LEN_W-1:0]      left_q;
    logic [LANE_IDX_W-1:0] idx_q;
    logic                  full_q;
    logic [WORD_W-1:0]     word_q;
    logic [LANE_IDX_W-1:0] sel;
    logic                  word_hs;
    logic                  byte_hs;

    // Handshake decode and byte selection.
    always_comb begin
        rxw_ready = (left_q != '0) && !full_q;
        word_hs   = rxw_valid && rxw_ready;
        rxb_valid = full_q;
        byte_hs   = full_q && rxb_ready;
        sel       = last_lane(bpw) - idx_q;
        rxb_data  = word_q[{sel, 3'b000} +: 8];
        rx_busy   = (left_q != '0);
    end

    // Word holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)       word_q <= '0;
        else if (word_hs) word_q <= rxw_data;
    end

    // Occupancy flag and byte pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            full_q <= 1'b0;
            idx_q  <= '0;
        end else if (word_hs) begin
            full_q <= 1'b1;
            idx_q  <= '0;
        end else if (byte_hs) begin
            if (idx_q == last_lane(bpw)) begin
                full_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q  <= idx_q + LANE_IDX_W'(1);
            end
        end
    end

    // Remaining byte count.
    always_ff @(posedge clk) begin
        if (!rst_n)       left_q <= '0;
        else if (load)    left_q <= xfer_len;
        else if (byte_hs) left_q <= left_q - LEN_W'(1);
    end

    // End-of-transfer pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= byte_hs && (left_q == LEN_W'(1));
    end

endmodule

// File: rtl/spi_word_packer.sv
// Top: byte streams on the client side, 32-bit word ports on the FIFO
// side, with a shared admission stage for transfers.
// Assumes the FIFO ready/valid lines mean "not full" and "not empty".
module spi_word_packer
    import spi_pack_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic [5:0]       frame_bits,
    output logic             busy,
    output logic             len_err,
    output logic             done,
    input  logic             txb_valid,
    output logic             txb_ready,
    input  logic [7:0]       txb_data,
    output logic             txw_valid,
    input  logic             txw_ready,
    output logic [31:0]      txw_data,
    input  logic             rxw_valid,
    output logic             rxw_ready,
    input  logic [31:0]      rxw_data,
    output logic             rxb_valid,
    input  logic             rxb_ready,
    output logic [7:0]       rxb_data
);

    logic load;
    bpw_e bpw;
    logic tx_busy;
    logic rx_busy;

    // Transfer runs while either path has work.
    always_comb busy = tx_busy || rx_busy;

    spi_len_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .xfer_len   (xfer_len),
        .frame_bits (frame_bits),
        .busy       (busy),
        .load       (load),
        .bpw        (bpw),
        .len_err    (len_err)
    );

    spi_tx_packer #(.LEN_W(LEN_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .xfer_len  (xfer_len),
        .bpw       (bpw),
        .txb_valid (txb_valid),
        .txb_ready (txb_ready),
        .txb_data  (txb_data),
        .txw_valid (txw_valid),
        .txw_ready (txw_ready),
        .txw_data  (txw_data),
        .tx_busy   (tx_busy)
    );

    spi_rx_unpacker #(.LEN_W(LEN_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .xfer_len  (xfer_len),
        .bpw       (bpw),
        .rxw_valid (rxw_valid),
        .rxw_ready (rxw_ready),
        .rxw_data  (rxw_data),
        .rxb_valid (rxb_valid),
        .rxb_ready (rxb_ready),
        .rxb_data  (rxb_data),
        .rx_busy   (rx_busy),
        .done      (done)
    );

endmodule

// File: rtl/spi_word_packer_chk.sv
// Protocol checker for spi_word_packer, attached by bind.
module spi_word_packer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        len_err,
    input logic        done,
    input logic        txb_ready,
    input logic        txw_valid,
    input logic        txw_ready,
    input logic [31:0] txw_data,
    input logic        rxw_ready,
    input logic        rxb_valid,
    input logic        rxb_ready,
    input logic [7:0]  rxb_data
);

    AST_TXW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        txw_valid && !txw_ready |=> txw_valid && $stable(txw_data)); // R3

    AST_TXB_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        txw_valid |-> !txb_ready); // R3

    AST_RXB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rxb_valid && !rxb_ready |=> rxb_valid && $stable(rxb_data)); // R5

    AST_RXW_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        rxb_valid |-> !rxw_ready); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !txb_ready && !rxw_ready && !txw_valid && !rxb_valid); // R6

    AST_REFUSED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> !busy); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(rxb_valid && rxb_ready)); // R8

    AST_BUSY_START_KEEPS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> !len_err); // R9

endmodule

bind spi_word_packer spi_word_packer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .len_err   (len_err),
    .done      (done),
    .txb_ready (txb_ready),
    .txw_valid (txw_valid),
    .txw_ready (txw_ready),
    .txw_data  (txw_data),
    .rxw_ready (rxw_ready),
    .rxb_valid (rxb_valid),
    .rxb_ready (rxb_ready),
    .rxb_data  (rxb_data)
);

// File: tb/spi_word_packer_test.sv
`timescale 1ns/1ps
module spi_word_packer_test;

    localparam int LW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] xfer_len = '0;
    logic [5:0]    frame_bits = '0;
    logic          busy, len_err, done;
    logic          txb_valid = 1'b0;
    logic          txb_ready;
    logic [7:0]    txb_data = '0;
    logic          txw_valid;
    logic          txw_ready = 1'b0;
    logic [31:0]   txw_data;
    logic          rxw_valid = 1'b0;
    logic          rxw_ready;
    logic [31:0]   rxw_data = '0;
    logic          rxb_valid;
    logic          rxb_ready = 1'b0;
    logic [7:0]    rxb_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    spi_word_packer #(.LEN_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len),
        .frame_bits(frame_bits), .busy(busy), .len_err(len_err), .done(done),
        .txb_valid(txb_valid), .txb_ready(txb_ready), .txb_data(txb_data),
        .txw_valid(txw_valid), .txw_ready(txw_ready), .txw_data(txw_data),
        .rxw_valid(rxw_valid), .rxw_ready(rxw_ready), .rxw_data(rxw_data),
        .rxb_valid(rxb_valid), .rxb_ready(rxb_ready), .rxb_data(rxb_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    function automatic int bpw_of(input int fb);
        if (fb <= 8) return 1;
        else if (fb <= 16) return 2;
        else return 4;
    endfunction

    function automatic logic [7:0] tx_byte(input int len, input int fb, input int k);
        return 8'((len * 7 + k * 13 + fb * 3 + 1) & 255);
    endfunction

    function automatic logic [31:0] rx_word(input int fb, input int j);
        return 32'(j) * 32'h0103_0507 + 32'h9abc_def1 + 32'(fb);
    endfunction

    // Expected packed word j: byte position i in bits 31-8i..24-8i, rest zero.
    function automatic logic [31:0] exp_tx_word(input int len, input int fb, input int j);
        logic [31:0] w = '0;
        int b = bpw_of(fb);
        for (int i = 0; i < b; i++)
            w[31-8*i -: 8] = tx_byte(len, fb, j*b + i);
        return w;
    endfunction

    function automatic logic [7:0] exp_rx_byte(input int fb, input int k);
        int b = bpw_of(fb);
        logic [31:0] w = rx_word(fb, k / b);
        return 8'(w >> (8 * (b - 1 - (k % b))));
    endfunction

    task automatic pulse_start(input int len, input int fb);
        start = 1'b1;
        xfer_len = LW'(len);
        frame_bits = 6'(fb);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic feed_tx(input int len, input int fb);
        for (int k = 0; k < len; k++) begin
            txb_valid = 1'b1;
            txb_data = tx_byte(len, fb, k);
            while (!txb_ready) @(negedge clk);
            @(negedge clk);
        end
        txb_valid = 1'b0;
    endtask

    task automatic drain_tx(input int len, input int fb, input int mode);
        int nw = len / bpw_of(fb);
        int cnt = 0;
        int cyc = 0;
        while (cnt < nw) begin
            txw_ready = (mode == 0) || (((cyc + mode) % 3) != 0);
            cyc++;
            if (txw_valid && txw_ready) begin
                chk("R1 R2 tx word", txw_data, exp_tx_word(len, fb, cnt));
                cnt++;
            end
            @(negedge clk);
        end
        txw_ready = 1'b0;
    endtask

    task automatic feed_rx(input int len, input int fb);
        int nw = len / bpw_of(fb);
        for (int j = 0; j < nw; j++) begin
            rxw_valid = 1'b1;
            rxw_data = rx_word(fb, j);
            while (!rxw_ready) @(negedge clk);
            @(negedge clk);
        end
        rxw_valid = 1'b0;
    endtask

    task automatic drain_rx(input int len, input int fb, input int mode);
        int cnt = 0;
        int cyc = 0;
        while (cnt < len) begin
            rxb_ready = (mode == 0) || (((cyc + 2 * mode) % 4) != 1);
            cyc++;
            if (rxb_valid && rxb_ready) begin
                chk("R4 rx byte", 32'(rxb_data), 32'(exp_rx_byte(fb, cnt)));
                cnt++;
                @(negedge clk);
                rxb_ready = 1'b0;
                chk("R8 done timing", 32'(done), 32'(cnt == len));
            end else begin
                @(negedge clk);
            end
        end
        rxb_ready = 1'b0;
        @(negedge clk);
        chk("R8 done one cycle", 32'(done), 32'd0);
    endtask

    task automatic run_xfer(input int fb, input int len, input int mode, input bit mid_start);
        pulse_start(len, fb);
        chk("R6 busy after start", 32'(busy), 32'd1);
        chk("R7 len_err clear on good start", 32'(len_err), 32'd0);
        fork
            feed_tx(len, fb);
            drain_tx(len, fb, mode);
            feed_rx(len, fb);
            drain_rx(len, fb, mode);
            begin
                if (mid_start) begin
                    @(negedge clk);
                    pulse_start(3, 16);   // R9: would be refused if taken
                    chk("R9 ignored start leaves len_err", 32'(len_err), 32'd0);
                end
            end
        join
        @(negedge clk);
        chk("R6 no more bytes taken", 32'(txb_ready), 32'd0);
        chk("R6 idle after transfer", 32'(busy), 32'd0);
        chk("R6 no word intake", 32'(rxw_ready), 32'd0);
    endtask

    task automatic bad_start(input int len, input int fb);
        pulse_start(len, fb);
        chk("R7 len_err raised", 32'(len_err), 32'd1);
        chk("R7 no transfer", 32'(busy), 32'd0);
        chk("R7 no byte intake", 32'(txb_ready), 32'd0);
        @(negedge clk);
        chk("R7 len_err held", 32'(len_err), 32'd1);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int fbs [6] = '{1, 8, 9, 16, 17, 32};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 busy", 32'(busy), 32'd0);
        chk("R10 done", 32'(done), 32'd0);
        chk("R10 len_err", 32'(len_err), 32'd0);
        chk("R10 txw_valid", 32'(txw_valid), 32'd0);
        chk("R10 rxb_valid", 32'(rxb_valid), 32'd0);
        chk("R10 txb_ready", 32'(txb_ready), 32'd0);
        chk("R10 rxw_ready", 32'(rxw_ready), 32'd0);

        // R1..R6, R8 sweep over frame widths, word counts and stall patterns
        for (int f = 0; f < 6; f++)
            for (int n = 1; n <= 5; n += 2)
                for (int m = 0; m < 3; m++)
                    run_xfer(fbs[f], n * bpw_of(fbs[f]), m, 1'b0);

        // R7 refused lengths
        bad_start(3, 16);
        bad_start(6, 32);
        bad_start(0, 8);
        run_xfer(32, 8, 1, 1'b0);
        bad_start(2, 17);
        run_xfer(8, 1, 2, 1'b0);

        // R9 start during a transfer
        run_xfer(16, 10, 1, 1'b1);
        run_xfer(32, 12, 2, 1'b1);

        summary();
        $finish;
    end

endmodule